// File: doc/BRIEF.md
# Pseudo-SRAM Low-Power Refresh Controller

This block sets the power state of a self-refreshing DRAM array that looks like a static RAM from the outside. The array is in one of three states. In active state reads and writes pass through. In standby, which needs both the chip-enable and the active-low sleep pin high, the whole array keeps being refreshed. In deep (partial-array) state, refresh covers only a chosen part of the array and every read and write request is dropped.

A one-byte configuration register holds the sleep-enable bit, the refresh span, the end of the address map the span is anchored to, and the refresh-rate choice. It can be written in two ways. A pin write is accepted only while the sleep pin is low. A software write always goes through, and it also locks out pin-based sleep entry until the next power-on reset. Refresh requests come out as single-cycle pulses, each with a row address. The row counter walks the kept region and wraps inside it. The spacing of the pulses comes from one of three fixed interval constants, or from a temperature-band input when the rate is automatic.

Top module: `psr_lowpower_ctl`

## Requirements
- R1: After reset the mode output is active (code 0), no refresh request is raised, pin sleep entry is unlocked, and the register holds 0x00: automatic rate, full span, low anchor, sleep disabled.
- R2: When the block is not in deep state, mode shows standby (code 1) exactly when ce_n and zz_n are both high, and active (code 0) otherwise.
- R3: With the register unlocked and sleep bit [4] set, once zz_n has been sampled low on HOLD_CYC = 10*CLK_MHZ consecutive rising edges the block is in deep state (mode code 2) from the following cycle. It never enters deep state while bit [4] is 0.
- R4: When unlocked, a high zz_n ends deep state in the same cycle, with no added delay. mode leaves code 2 and requests pass through at once.
- R5: In deep state rd_req and wr_req are ignored: mem_rd and mem_wr stay low.
- R6: Span field [2:0] selects full (0), half (1), quarter (2) or eighth (3) of the rows for refresh in deep state. Values 4 to 7 mean no rows, and no refresh request is raised.
- R7: Anchor bit [3] = 0 places the refreshed span at the lowest rows. A value of 1 places it at the highest rows.
- R8: Each refresh request uses the next row in sequence within the current span, wrapping back to the span's first row after its last.
- R9: Outside deep state, refresh covers all 2^ROW_W rows, whatever the span and anchor fields hold.
- R10: A software write (sw_cfg_wr) loads cfg_wdata[6:0] in one cycle. If bit [4] is 1, the block is in deep state from the next cycle whatever zz_n is, and a later software write with bit [4] = 0 takes it out again.
- R11: After any software write, zz_n no longer starts or ends deep state until reset. Pin writes (pin_cfg_wr) are still accepted while zz_n is low, and pin writes with zz_n high are ignored at all times.
- R12: Rate field [6:5] sets the request spacing: 1 = IV_85 cycles, 2 = IV_45, 3 = IV_15. In automatic mode (0) the spacing follows temp_band 0/1/2/3 as IV_15/IV_45/IV_85/IV_85/2. A request is raised every interval cycles, and the first one comes interval cycles after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ce_n | input | 1 | Active-low chip enable |
| zz_n | input | 1 | Active-low sleep pin |
| rd_req | input | 1 | Read request from the access path |
| wr_req | input | 1 | Write request from the access path |
| pin_cfg_wr | input | 1 | Register write strobe, pin method |
| sw_cfg_wr | input | 1 | Register write strobe, software access method |
| cfg_wdata | input | 8 | Register write value |
| temp_band | input | 2 | Temperature band from the sensor comparator |
| mem_rd | output | 1 | Read passed to the array |
| mem_wr | output | 1 | Write passed to the array |
| ref_req | output | 1 | Refresh request pulse |
| ref_row | output | ROW_W | Row to refresh, valid with ref_req |
| mode | output | 2 | Power state: 0 active, 1 standby, 2 deep |

## Verification
A hold counter that is off by one shows up as mode reaching code 2 one cycle early or late after zz_n falls. A stale lock flag shows up as zz_n changing mode when it should not. A wrong span mask or anchor puts a row outside the kept region on the first ref_req after deep entry. A slipped row counter breaks the wrap order within one span's worth of requests. A wrong interval moves the next ref_req pulse by at least one cycle. The bench's reference model checks mode, mem_rd, mem_wr, ref_req and ref_row on every clock, so each of these faults is caught in the cycle where it first becomes visible.

// File: rtl/psr_pkg.sv
package psr_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE  = 2'd0,
        PM_STANDBY = 2'd1,
        PM_DEEP    = 2'd2
    } pwr_mode_e;

    typedef enum logic [1:0] {
        RATE_AUTO = 2'd0,
        RATE_T85  = 2'd1,
        RATE_T45  = 2'd2,
        RATE_T15  = 2'd3
    } rate_sel_e;

    // register byte: [7] unused, [6:5] rate, [4] sleep, [3] anchor, [2:0] span
    typedef struct packed {
        logic      spare;
        rate_sel_e rate;
        logic      sleep;
        logic      top_end;
        logic [2:0] span;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{spare: 1'b0, rate: RATE_AUTO, sleep: 1'b0,
                                   top_end: 1'b0, span: 3'd0};

    function automatic cfg_t cfg_from_byte(input logic [7:0] b);
        cfg_t c;
        c.spare   = 1'b0;
        c.rate    = rate_sel_e'(b[6:5]);
        c.sleep   = b[4];
        c.top_end = b[3];
        c.span    = b[2:0];
        return c;
    endfunction

    function automatic logic span_is_none(input logic [2:0] s);
        return s[2];
    endfunction

    function automatic logic [1:0] span_shift(input logic [2:0] s);
        return s[1:0];
    endfunction

endpackage

// File: rtl/psr_cfg_reg.sv
module psr_cfg_reg
    import psr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       zz_n,
    input  logic       pin_wr,
    input  logic       sw_wr,
    input  logic [7:0] wdata,
    output cfg_t       cfg,
    output logic       lock
);

    logic pin_ok;
    assign pin_ok = pin_wr && !zz_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= CFG_RESET;
            lock <= 1'b0;
        end else begin
            if (sw_wr) begin
                cfg  <= cfg_from_byte(wdata);
                lock <= 1'b1;
            end else if (pin_ok) begin
                cfg <= cfg_from_byte(wdata);
            end
        end
    end

    assert_sw_load_R10: assert property (@(posedge clk) disable iff (rst)
        sw_wr |=> (cfg == {1'b0, $past(wdata[6:0])}));

    assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        $past(lock) |-> lock);

    assert_pin_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (!sw_wr && zz_n) |=> $stable(cfg));

endmodule

// File: rtl/psr_sleep_ctl.sv
module psr_sleep_ctl
    import psr_pkg::*;
#(
    parameter int HOLD_CYC = 1250
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      zz_n,
    input  logic      ce_n,
    input  logic      sleep_en,
    input  logic      lock,
    output logic      deep,
    output pwr_mode_e mode
);

    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_V = HW'(HOLD_CYC);

    logic [HW-1:0] hold_cnt;
    logic          hold_done;
    logic          pin_term;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
        end else if (zz_n) begin
            hold_cnt <= '0;
        end else if (hold_cnt != HOLD_V) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    assign hold_done = (hold_cnt == HOLD_V);
    assign pin_term  = !zz_n && hold_done;
    assign deep      = sleep_en && (lock || pin_term);

    always_comb begin
        if (deep)               mode = PM_DEEP;
        else if (ce_n && zz_n)  mode = PM_STANDBY;
        else                    mode = PM_ACTIVE;
    end

    assert_pin_entry_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(deep) && !lock) |-> $past(!zz_n));

    assert_no_sleep_R3: assert property (@(posedge clk) disable iff (rst)
        !sleep_en |-> (mode != PM_DEEP));

endmodule

// File: rtl/psr_refresh.sv
module psr_refresh
    import psr_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int IV_15  = 7800,
    parameter int IV_45  = 3900,
    parameter int IV_85  = 1950
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             deep,
    input  cfg_t             cfg,
    input  logic [1:0]       temp_band,
    output logic             ref_req,
    output logic [ROW_W-1:0] ref_row
);

    localparam int TW = $clog2(IV_15 + 1);
    localparam logic [TW-1:0] IVV_15  = TW'(IV_15);
    localparam logic [TW-1:0] IVV_45  = TW'(IV_45);
    localparam logic [TW-1:0] IVV_85  = TW'(IV_85);
    localparam logic [TW-1:0] IVV_HOT = TW'(IV_85 / 2);

    logic [TW-1:0]    interval;
    logic [TW-1:0]    tmr;
    logic             fire;
    logic             region_none;
    logic [1:0]       sh;
    logic [ROW_W-1:0] mask;
    logic [ROW_W-1:0] base;
    logic [ROW_W-1:0] offs;

    always_comb begin
        unique case (cfg.rate)
            RATE_T85: interval = IVV_85;
            RATE_T45: interval = IVV_45;
            RATE_T15: interval = IVV_15;
            default: begin
                unique case (temp_band)
                    2'd0:    interval = IVV_15;
                    2'd1:    interval = IVV_45;
                    2'd2:    interval = IVV_85;
                    default: interval = IVV_HOT;
                endcase
            end
        endcase
    end

    assign fire        = (tmr >= interval - 1'b1);
    assign region_none = deep && span_is_none(cfg.span);
    assign sh          = deep ? span_shift(cfg.span) : 2'd0;
    assign mask        = {ROW_W{1'b1}} >> sh;
    assign base        = (deep && cfg.top_end) ? ~mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr     <= '0;
            offs    <= '0;
            ref_req <= 1'b0;
            ref_row <= '0;
        end else begin
            tmr     <= fire ? '0 : tmr + 1'b1;
            ref_req <= fire && !region_none;
            if (fire && !region_none) begin
                ref_row <= base | (offs & mask);
                offs    <= offs + 1'b1;
            end
        end
    end

    assert_none_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        $past(deep && cfg.span[2]) |-> !ref_req);

    assert_eighth_anchor_R7: assert property (@(posedge clk) disable iff (rst)
        (ref_req && $past(deep) && $past(cfg.span) == 3'd3)
            |-> (ref_row[ROW_W-1 -: 3] == {3{$past(cfg.top_end)}}));

    assert_timer_bound_R12: assert property (@(posedge clk) disable iff (rst)
        tmr < IVV_15);

endmodule

// File: rtl/psr_lowpower_ctl.sv
module psr_lowpower_ctl
    import psr_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int CLK_MHZ = 125,
    parameter int IV_15   = 7800,
    parameter int IV_45   = 3900,
    parameter int IV_85   = 1950
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_n,
    input  logic             zz_n,
    input  logic             rd_req,
    input  logic             wr_req,
    input  logic             pin_cfg_wr,
    input  logic             sw_cfg_wr,
    input  logic [7:0]       cfg_wdata,
    input  logic [1:0]       temp_band,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ref_req,
    output logic [ROW_W-1:0] ref_row,
    output logic [1:0]       mode
);

    localparam int HOLD_CYC = 10 * CLK_MHZ;

    cfg_t      cfg;
    logic      lock;
    logic      deep;
    pwr_mode_e pmode;

    psr_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .zz_n   (zz_n),
        .pin_wr (pin_cfg_wr),
        .sw_wr  (sw_cfg_wr),
        .wdata  (cfg_wdata),
        .cfg    (cfg),
        .lock   (lock)
    );

    psr_sleep_ctl #(.HOLD_CYC(HOLD_CYC)) u_sleep (
        .clk      (clk),
        .rst      (rst),
        .zz_n     (zz_n),
        .ce_n     (ce_n),
        .sleep_en (cfg.sleep),
        .lock     (lock),
        .deep     (deep),
        .mode     (pmode)
    );

    psr_refresh #(
        .ROW_W (ROW_W),
        .IV_15 (IV_15),
        .IV_45 (IV_45),
        .IV_85 (IV_85)
    ) u_ref (
        .clk       (clk),
        .rst       (rst),
        .deep      (deep),
        .cfg       (cfg),
        .temp_band (temp_band),
        .ref_req   (ref_req),
        .ref_row   (ref_row)
    );

    assign mem_rd = rd_req && !deep;
    assign mem_wr = wr_req && !deep;
    assign mode   = pmode;

    assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_DEEP) |-> (!mem_rd && !mem_wr));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!ref_req && mode != PM_DEEP));

endmodule

// File: tb/tb_psr_lowpower_ctl.sv
module tb_psr_lowpower_ctl;

    localparam int ROW_W = 5;
    localparam int ROWS  = 1 << ROW_W;
    localparam int CLKM  = 2;
    localparam int HOLD  = 10 * CLKM;
    localparam int I15   = 16;
    localparam int I45   = 10;
    localparam int I85   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, zz_n = 1'b1, rd_req = 1'b0, wr_req = 1'b0;
    logic pin_cfg_wr = 1'b0, sw_cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [1:0] temp_band = 2'd0;
    logic mem_rd, mem_wr, ref_req;
    logic [ROW_W-1:0] ref_row;
    logic [1:0] mode;

    always #4 clk = ~clk;

    psr_lowpower_ctl #(.ROW_W(ROW_W), .CLK_MHZ(CLKM), .IV_15(I15), .IV_45(I45), .IV_85(I85)) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .zz_n(zz_n), .rd_req(rd_req), .wr_req(wr_req),
        .pin_cfg_wr(pin_cfg_wr), .sw_cfg_wr(sw_cfg_wr), .cfg_wdata(cfg_wdata),
        .temp_band(temp_band), .mem_rd(mem_rd), .mem_wr(mem_wr), .ref_req(ref_req),
        .ref_row(ref_row), .mode(mode)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    string phase = "R1";

    // behavioural reference state
    int m_rate, m_sleep, m_top, m_span, m_lock, m_hc, m_t, m_off, m_req, m_row;

    function automatic int pick_iv(int rate, int band);
        case (rate)
            1: return I85;
            2: return I45;
            3: return I15;
            default: case (band)
                0: return I15;
                1: return I45;
                2: return I85;
                default: return I85 / 2;
            endcase
        endcase
    endfunction

    function automatic bit m_deep();
        return (m_sleep != 0) && ((m_lock != 0) || (!zz_n && m_hc == HOLD));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_rate = 0; m_sleep = 0; m_top = 0; m_span = 0; m_lock = 0;
            m_hc = 0; m_t = 0; m_off = 0; m_req = 0; m_row = 0;
        end else begin
            bit dp;
            int iv, rows, first;
            dp = m_deep();
            iv = pick_iv(m_rate, temp_band);
            if (m_t >= iv - 1) begin
                m_t = 0;
                if (dp && m_span >= 4) m_req = 0;
                else begin
                    rows  = dp ? (ROWS >> m_span) : ROWS;
                    first = (dp && m_top != 0) ? ROWS - rows : 0;
                    m_req = 1;
                    m_row = first + (m_off % rows);
                    m_off = (m_off + 1) % ROWS;
                end
            end else begin
                m_t++;
                m_req = 0;
            end
            if (zz_n) m_hc = 0;
            else if (m_hc < HOLD) m_hc++;
            if (sw_cfg_wr || (pin_cfg_wr && !zz_n)) begin
                m_rate  = cfg_wdata[6:5];
                m_sleep = cfg_wdata[4];
                m_top   = cfg_wdata[3];
                m_span  = cfg_wdata[2:0];
                if (sw_cfg_wr) m_lock = 1;
            end
        end
    end

    task automatic compare();
        int em;
        bit dp, bad;
        dp = m_deep();
        em = dp ? 2 : ((ce_n && zz_n) ? 1 : 0);
        bad = (int'(mode) != em) || (mem_rd != (rd_req && !dp)) ||
              (mem_wr != (wr_req && !dp)) || (int'(ref_req) != m_req) ||
              (m_req != 0 && int'(ref_row) != m_row);
        n_cmp++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s t=%0t: mode=%0d/%0d rd=%0b/%0b wr=%0b/%0b req=%0b/%0d row=%0d/%0d",
                     phase, $time, mode, em, mem_rd, rd_req && !dp, mem_wr, wr_req && !dp,
                     ref_req, m_req, ref_row, m_row);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    task automatic run(int n);
        repeat (n) tick();
    endtask

    task automatic pin_write(logic [7:0] b);
        cfg_wdata = b; pin_cfg_wr = 1'b1;
        tick();
        pin_cfg_wr = 1'b0;
    endtask

    task automatic sw_write(logic [7:0] b);
        cfg_wdata = b; sw_cfg_wr = 1'b1;
        tick();
        sw_cfg_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        phase = "R1"; run(4);

        phase = "R2";
        ce_n = 1'b1; zz_n = 1'b1; run(5);
        ce_n = 1'b0; rd_req = 1'b1; run(3);
        ce_n = 1'b1; zz_n = 1'b0; rd_req = 1'b0; wr_req = 1'b1; run(3);
        wr_req = 1'b0;

        phase = "R12";
        zz_n = 1'b0;
        pin_write(8'h00);
        for (int b = 0; b < 4; b++) begin temp_band = b[1:0]; run(35); end
        temp_band = 2'd0;
        pin_write(8'h20); run(30);
        pin_write(8'h40); run(30);
        pin_write(8'h60); run(40);
        pin_write(8'h00);

        phase = "R3";
        pin_write(8'h11);
        zz_n = 1'b1; run(2);
        zz_n = 1'b0;
        for (int k = 0; k < 28; k++) begin rd_req = k[0]; wr_req = ~k[0]; tick(); end

        phase = "R5";
        rd_req = 1'b1; wr_req = 1'b1; run(6);

        phase = "R4";
        zz_n = 1'b1; run(3);
        rd_req = 1'b0; wr_req = 1'b0;

        phase = "R6";
        temp_band = 2'd3;
        for (int sp = 0; sp < 5; sp++) begin
            for (int d = 0; d < 2; d++) begin
                phase = (d == 0) ? "R6" : "R7";
                zz_n = 1'b0;
                pin_write({3'b000, 1'b1, d[0], sp[2:0]});
                phase = "R8";
                run(70);
                zz_n = 1'b1; run(3);
            end
        end
        zz_n = 1'b0; pin_write(8'h17); run(40); zz_n = 1'b1;

        phase = "R9";
        for (int k = 0; k < 40; k++) begin ce_n = k[2]; tick(); end
        ce_n = 1'b1;

        phase = "R11";
        zz_n = 1'b0; pin_write(8'h11); zz_n = 1'b1;
        cfg_wdata = 8'h13; pin_cfg_wr = 1'b1; tick(); pin_cfg_wr = 1'b0;
        zz_n = 1'b0; run(30); zz_n = 1'b1; run(2);

        phase = "R10";
        sw_write(8'h1A); run(30);

        phase = "R11";
        for (int k = 0; k < 20; k++) begin zz_n = k[1]; tick(); end
        zz_n = 1'b0; pin_write(8'h1B); run(30);
        zz_n = 1'b1; run(5);

        phase = "R10";
        sw_write(8'h02); run(10);

        phase = "R11";
        zz_n = 1'b0; run(30);
        pin_write(8'h12); run(12);
        zz_n = 1'b1; run(8);

        phase = "R1";
        rst = 1'b1; run(2); rst = 1'b0; run(5);

        finish_run();
    end

endmodule